// File: doc/BRIEF.md
# Reload/Capture Timer with Toggle Output

This block is a core up/down timer with a toggle output and a small set of auxiliary registers, two by default. The core timer steps once per enabled cycle and wraps modulo its width. Each wrap flips the toggle latch: this is an overflow when counting up from all-ones, or an underflow when counting down from zero. The latch level is an output. It can be used for time-out monitoring, or as a waveform in its own right.

Each auxiliary register is set to one of two roles.

- **Capture:** a synchronized edge on the register's own pin copies the live timer value into it.
- **Reload:** it loads the timer. The trigger is either a pin edge or a chosen transition (rising or falling) of the toggle latch.

In reload mode the register can still be written by software, but it never counts by itself. Suppose register 0 reloads on the latch's rising transition and register 1 on its falling transition. The latch then produces a continuous PWM waveform whose high and low times are set by the two register values. No further software action is needed.

Top module: `ptmr_top`

## Requirements
- R1: After reset the timer, all auxiliary registers, the toggle latch and all event flags are zero.
- R2: With count enable high the timer moves by one per cycle, upward when the direction input is 0 and downward when it is 1, wrapping modulo 2^W. With count enable low and no write or reload, it holds its value.
- R3: The toggle latch inverts on the clock edge where the timer wraps (up from all-ones or down from zero while enabled). It keeps its level on every other edge.
- R4: An auxiliary register in capture mode (capture bit 1) takes the timer value present on the third clock edge after its pin changes. The pin passes through two synchronizing flops, then one edge-detect flop. The 2-bit edge code per register selects which pin changes count: 00 none, 01 rising, 10 falling, 11 both.
- R5: In reload mode (capture bit 0) a register never changes by itself. When its trigger fires, the timer is loaded with its value. With the source bit 0 the trigger is a pin edge, selected and timed as in R4. With the source bit 1 the trigger is a latch transition: rising when the polarity bit is 0, falling when it is 1.
- R6: A reload triggered by a latch transition lands on the same edge as the wrap that caused it. The timer shows the reload value in the first cycle of the new latch level.
- R7: With register 0 reloading on the rising transition (value A) and register 1 on the falling transition (value B), the latch runs as PWM. Counting up, it is high for 2^W−A cycles and low for 2^W−B cycles. Counting down, it is high for A+1 cycles and low for B+1 cycles.
- R8: A hardware reload takes priority over a software timer write in the same cycle. When several registers reload together, the lowest-indexed one supplies the value.
- R9: Each capture or reload raises that register's event flag for exactly the one cycle after the edge on which it happened.
- R10: Software writes load the timer or any auxiliary register on the next edge. A capture in the same cycle takes priority over a write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable for the core timer |
| cnt_down_i | input | 1 | Count direction, 1 = down |
| aux_pin_i | input | N_AUX | Asynchronous event pin per auxiliary register |
| aux_cap_i | input | N_AUX | Role per register: 1 capture, 0 reload |
| aux_edge_i | input | 2*N_AUX | Pin edge code per register (00 none, 01 rise, 10 fall, 11 both) |
| aux_src_lat_i | input | N_AUX | Reload source: 0 pin edge, 1 latch transition |
| aux_lat_fall_i | input | N_AUX | Latch transition used: 0 rising, 1 falling |
| tmr_wr_i | input | 1 | Software write strobe for the timer |
| aux_wr_i | input | N_AUX | Software write strobe per auxiliary register |
| wr_data_i | input | W | Shared write data |
| tmr_o | output | W | Current timer value |
| aux_val_o | output | N_AUX*W | Auxiliary register values, register k in bits k*W +: W |
| tgl_o | output | 1 | Toggle latch level |
| aux_evt_o | output | N_AUX | One-cycle capture/reload event flag per register |

## Verification
The hardest situation to reach is a reload in the exact cycle of a wrap, repeated back to back so that the latch level alternates with durations set by two registers. The stimulus stops the timer and programs both registers for opposite latch transitions. It then starts the timer one step before the wrap and measures full high and low runs after the first transition, for a grid of values that includes the one-cycle extremes, in both directions. A second situation that is hard to reach is the collision of a pin-triggered reload or capture with a software write. It is produced by asserting the write strobe exactly two edges after the pin change, so that the write meets the third edge together with the detected event.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   typedef enum logic [1:0] {
      EDG_NONE = 2'b00,
      EDG_RISE = 2'b01,
      EDG_FALL = 2'b10,
      EDG_ANY  = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/ptmr_pin_detect.sv
module ptmr_pin_detect
   import ptmr_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pin_i,
   input  logic [1:0] sel_i,
   output logic       evt_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ptmr_pin_detect: STAGES must be at least 2");
   end

   logic [STAGES:0] shr_q;
   logic            lvl, prv, rise_on, fall_on;
   edge_sel_e       sel;

   assign sel     = edge_sel_e'(sel_i);
   assign lvl     = shr_q[STAGES-1];
   assign prv     = shr_q[STAGES];
   assign rise_on = (sel == EDG_RISE) || (sel == EDG_ANY);
   assign fall_on = (sel == EDG_FALL) || (sel == EDG_ANY);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shr_q <= '0;
      else         shr_q <= {shr_q[STAGES-1:0], pin_i};
   end

   assign evt_o = (rise_on && lvl && !prv) || (fall_on && !lvl && prv);

   // R4: a detected event always follows a change of the synchronized level
   a_r4_evt_after_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |=> (shr_q[STAGES] != $past(shr_q[STAGES])));
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         en_i,
   input  logic         down_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         wr_i,
   input  logic [W-1:0] wr_val_i,
   output logic [W-1:0] cnt_o,
   output logic         tgl_o,
   output logic         tgl_rise_o,
   output logic         tgl_fall_o
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic [W-1:0] cnt_q, step;
   logic         tgl_q, wrap;

   assign wrap = en_i && (down_i ? (cnt_q == '0) : (cnt_q == CNT_MAX));
   assign step = down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         tgl_q <= 1'b0;
      end else begin
         if (ld_i)      cnt_q <= ld_val_i;
         else if (wr_i) cnt_q <= wr_val_i;
         else if (en_i) cnt_q <= step;
         tgl_q <= tgl_q ^ wrap;
      end
   end

   assign cnt_o      = cnt_q;
   assign tgl_o      = tgl_q;
   assign tgl_rise_o = wrap && !tgl_q;
   assign tgl_fall_o = wrap && tgl_q;

   a_r3_latch_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap |=> (tgl_q != $past(tgl_q)));
   a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap |=> $stable(tgl_q));
   a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !ld_i && !wr_i) |=> $stable(cnt_q));
   a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !down_i && !ld_i && !wr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ptmr_aux.sv
module ptmr_aux #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         cap_mode_i,
   input  logic         pin_evt_i,
   input  logic         src_lat_i,
   input  logic         lat_fall_i,
   input  logic         tgl_rise_i,
   input  logic         tgl_fall_i,
   input  logic         wr_i,
   input  logic [W-1:0] wr_val_i,
   input  logic [W-1:0] tmr_i,
   output logic         rl_o,
   output logic [W-1:0] val_o,
   output logic         evt_o
);
   logic         cap, lat_hit, evt_q;
   logic [W-1:0] val_q;

   assign cap     = cap_mode_i && pin_evt_i;
   assign lat_hit = lat_fall_i ? tgl_fall_i : tgl_rise_i;
   assign rl_o    = !cap_mode_i && (src_lat_i ? lat_hit : pin_evt_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         val_q <= '0;
         evt_q <= 1'b0;
      end else begin
         if (cap)       val_q <= tmr_i;
         else if (wr_i) val_q <= wr_val_i;
         evt_q <= cap || rl_o;
      end
   end

   assign val_o = val_q;
   assign evt_o = evt_q;

   a_r4_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap |=> (val_q == $past(tmr_i)));
   a_r5_no_self_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cap && !wr_i) |=> $stable(val_q));
   a_r9_evt_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap || rl_o) |=> evt_q);
   a_r9_evt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cap || rl_o) |=> !evt_q);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
   parameter int W           = 16,
   parameter int N_AUX       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cnt_en_i,
   input  logic               cnt_down_i,
   input  logic [N_AUX-1:0]   aux_pin_i,
   input  logic [N_AUX-1:0]   aux_cap_i,
   input  logic [2*N_AUX-1:0] aux_edge_i,
   input  logic [N_AUX-1:0]   aux_src_lat_i,
   input  logic [N_AUX-1:0]   aux_lat_fall_i,
   input  logic               tmr_wr_i,
   input  logic [N_AUX-1:0]   aux_wr_i,
   input  logic [W-1:0]       wr_data_i,
   output logic [W-1:0]       tmr_o,
   output logic [N_AUX*W-1:0] aux_val_o,
   output logic               tgl_o,
   output logic [N_AUX-1:0]   aux_evt_o
);
   if (W < 2) begin : g_bad_w
      $error("ptmr_top: W must be at least 2");
   end
   if (N_AUX < 1) begin : g_bad_n
      $error("ptmr_top: N_AUX must be at least 1");
   end

   logic [N_AUX-1:0] pin_evt, rl;
   logic             rl_any, tgl_rise, tgl_fall;
   logic [W-1:0]     rl_val;

   for (genvar k = 0; k < N_AUX; k++) begin : g_aux
      ptmr_pin_detect #(.STAGES(SYNC_STAGES)) u_pin (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .pin_i  (aux_pin_i[k]),
         .sel_i  (aux_edge_i[2*k +: 2]),
         .evt_o  (pin_evt[k])
      );
      ptmr_aux #(.W(W)) u_reg (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .cap_mode_i (aux_cap_i[k]),
         .pin_evt_i  (pin_evt[k]),
         .src_lat_i  (aux_src_lat_i[k]),
         .lat_fall_i (aux_lat_fall_i[k]),
         .tgl_rise_i (tgl_rise),
         .tgl_fall_i (tgl_fall),
         .wr_i       (aux_wr_i[k]),
         .wr_val_i   (wr_data_i),
         .tmr_i      (tmr_o),
         .rl_o       (rl[k]),
         .val_o      (aux_val_o[k*W +: W]),
         .evt_o      (aux_evt_o[k])
      );
   end

   // lowest index wins: scan from the top so lower indices overwrite
   always_comb begin
      rl_any = 1'b0;
      rl_val = '0;
      for (int k = N_AUX - 1; k >= 0; k--) begin
         if (rl[k]) begin
            rl_any = 1'b1;
            rl_val = aux_val_o[k*W +: W];
         end
      end
   end

   ptmr_core #(.W(W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cnt_en_i),
      .down_i     (cnt_down_i),
      .ld_i       (rl_any),
      .ld_val_i   (rl_val),
      .wr_i       (tmr_wr_i),
      .wr_val_i   (wr_data_i),
      .cnt_o      (tmr_o),
      .tgl_o      (tgl_o),
      .tgl_rise_o (tgl_rise),
      .tgl_fall_o (tgl_fall)
   );

   a_r8_reload_over_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rl_any && tmr_wr_i) |=> (tmr_o == $past(rl_val)));
   a_r8_low_index_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rl[0] |=> (tmr_o == $past(aux_val_o[W-1:0])));
endmodule

// File: tb/ptmr_top_tb_top.sv
`timescale 1ns/1ps
module ptmr_top_tb_top;
   localparam int W = 6;
   localparam int M = 1 << W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0, dir_dn = 1'b0, tmr_wr = 1'b0;
   logic [1:0]  pin = '0, cap = '0, src_lat = '0, lat_fall = '0, aux_wr = '0;
   logic [3:0]  edg = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] tmr;
   logic [2*W-1:0] auxv;
   logic        tgl;
   logic [1:0]  evt;

   int n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   ptmr_top #(.W(W), .N_AUX(2), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .cnt_down_i(dir_dn),
      .aux_pin_i(pin), .aux_cap_i(cap), .aux_edge_i(edg),
      .aux_src_lat_i(src_lat), .aux_lat_fall_i(lat_fall),
      .tmr_wr_i(tmr_wr), .aux_wr_i(aux_wr), .wr_data_i(wdata),
      .tmr_o(tmr), .aux_val_o(auxv), .tgl_o(tgl), .aux_evt_o(evt)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_tmr(int v);
      tmr_wr = 1'b1; wdata = W'(v); tick(); tmr_wr = 1'b0;
   endtask

   task automatic wr_aux(int k, int v);
      aux_wr[k] = 1'b1; wdata = W'(v); tick(); aux_wr = '0;
   endtask

   task automatic settle();
      cnt_en = 1'b0; edg = '0; pin = '0;
      repeat (4) tick();
   endtask

   // R6 R7: measure two full latch runs after the first observed transition
   task automatic pwm_run(int a, int b, bit down);
      logic lvl;
      int   len, rv, ex;
      cnt_en = 1'b0; dir_dn = down;
      cap = '0; src_lat = 2'b11; lat_fall = 2'b10; edg = '0;
      wr_aux(0, a); wr_aux(1, b);
      wr_tmr(down ? 1 : M - 2);
      cnt_en = 1'b1;
      lvl = tgl; len = 0;
      while (tgl == lvl && len < 3 * M) begin tick(); len++; end
      for (int r = 0; r < 2; r++) begin
         lvl = tgl;
         rv = lvl ? a : b;
         check("R6 reload value at latch transition", int'(tmr), rv);
         len = 0;
         while (tgl == lvl && len < 3 * M) begin tick(); len++; end
         ex = down ? rv + 1 : M - rv;
         check(lvl ? "R7 high time" : "R7 low time", len, ex);
      end
      cnt_en = 1'b0;
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run not finished actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int et, el, pv, ev, ax;
      bit hit;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1
      check("R1 timer reset", int'(tmr), 0);
      check("R1 aux reset", int'(auxv), 0);
      check("R1 latch reset", int'(tgl), 0);
      check("R1 flags reset", int'(evt), 0);

      // R2 R3 up sweep
      cnt_en = 1'b1; dir_dn = 1'b0; et = 0; el = 0;
      for (int i = 0; i < 2 * M + 10; i++) begin
         tick();
         if (et == M - 1) el ^= 1;
         et = (et + 1) % M;
         check("R2 up count", int'(tmr), et);
         check("R3 latch up", int'(tgl), el);
      end
      // R2 R3 down sweep
      dir_dn = 1'b1;
      for (int i = 0; i < 2 * M + 10; i++) begin
         tick();
         if (et == 0) el ^= 1;
         et = (et + M - 1) % M;
         check("R2 down count", int'(tmr), et);
         check("R3 latch down", int'(tgl), el);
      end
      cnt_en = 1'b0;
      repeat (5) tick();
      check("R2 hold when disabled", int'(tmr), et);
      check("R3 latch holds", int'(tgl), el);

      // R10 writes
      wr_tmr(45);
      check("R10 timer write", int'(tmr), 45);
      wr_aux(1, 17);
      check("R10 aux1 write", int'(auxv[2*W-1:W]), 17);

      // R4 R9 capture sweep over edge codes, register 0 in capture mode, counting
      wr_aux(0, 50);
      pv = 50; cap = 2'b01; dir_dn = 1'b0; cnt_en = 1'b1;
      for (int c = 0; c < 4; c++) begin
         edg[1:0] = 2'(c);
         for (int ph = 0; ph < 2; ph++) begin
            pin[0] = ~pin[0];
            tick(); tick();
            ev = int'(tmr);
            tick();
            hit = (ph == 0) ? c[0] : c[1];
            ex_chk: begin
               ax = hit ? ev : pv;
               check("R4 capture by edge code", int'(auxv[W-1:0]), ax);
               check("R9 capture flag", int'(evt[0]), int'(hit));
               pv = ax;
            end
            tick();
            check("R9 flag lasts one cycle", int'(evt[0]), 0);
            check("R4 no capture without edge", int'(auxv[W-1:0]), pv);
         end
      end
      // R4 register 1 on both edges
      settle();
      cap = 2'b10; edg = 4'b1100; cnt_en = 1'b1;
      pin[1] = 1'b1; tick(); tick(); ev = int'(tmr); tick();
      check("R4 capture register 1", int'(auxv[2*W-1:W]), ev);

      // R10 capture beats write
      settle();
      cap = 2'b01; edg = 4'b0001; cnt_en = 1'b1;
      pin[0] = 1'b1; tick(); tick();
      aux_wr[0] = 1'b1; wdata = W'(33); ev = int'(tmr);
      tick(); aux_wr = '0;
      check("R10 capture wins over write", int'(auxv[W-1:0]), ev);

      // R5 R9 pin-triggered reload
      settle();
      cap = '0; src_lat = '0; wr_aux(0, 10); wr_aux(1, 40);
      edg = 4'b0001; wr_tmr(20); cnt_en = 1'b1;
      pin[0] = 1'b1; tick(); tick(); tick();
      check("R5 pin reload value", int'(tmr), 10);
      check("R9 reload flag", int'(evt[0]), 1);
      check("R5 reload register unchanged", int'(auxv[W-1:0]), 10);
      tick();
      check("R5 counting after reload", int'(tmr), 11);
      check("R9 reload flag clears", int'(evt[0]), 0);
      check("R5 idle reload register unchanged", int'(auxv[2*W-1:W]), 40);

      // R8 reload beats write, low index wins
      settle();
      wr_aux(0, 7); wr_aux(1, 9);
      edg = 4'b0101; cnt_en = 1'b1;
      pin = 2'b11; tick(); tick();
      tmr_wr = 1'b1; wdata = W'(20);
      tick(); tmr_wr = 1'b0;
      check("R8 reload beats write / low index", int'(tmr), 7);
      check("R9 both flags", int'(evt), 3);

      // R5 latch-transition trigger ignores pin edges
      settle();
      src_lat = 2'b01; lat_fall = 2'b00; edg = 4'b0001; wr_aux(0, 30);
      wr_tmr(5); pin[0] = 1'b1; repeat (4) tick();
      check("R5 latch source ignores pin", int'(tmr), 5);

      // R6 R7 PWM sweep
      settle();
      for (int ia = 0; ia < 5; ia++) begin
         for (int ib = 0; ib < 5; ib++) begin
            int va[5] = '{0, 5, 31, 62, 63};
            pwm_run(va[ia], va[ib], 1'b0);
         end
      end
      pwm_run(4, 11, 1'b1);
      pwm_run(0, 63, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule